// File: doc/BRIEF.md
# Converter-Side Serial Port

This block is the digital front end of a successive-approximation converter. It talks to a host over a four-wire serial link made of a chip select, a serial clock, a serial address line and a data line that can be released. Everything runs on a fast internal clock. The three serial inputs pass through two-flop synchronizers. The serial clock's edges are then found by comparing it with its previous synchronized value. Chip select takes effect only after it has held a new level for a set number of internal cycles.

In each frame the host shifts a 4-bit channel number in on rising serial-clock edges and reads back the previous conversion result on the data line. The result leaves MSB first and advances on falling edges. The block opens a sample window at the fourth falling edge. At the tenth falling edge it closes the window, pulses a start to the external conversion engine and forces the data line low, so frames of up to 16 clocks read back zeros after the result. The engine answers with a done pulse and a result word.

When chip select stays low between frames, the new result is presented again in one of two ways. In fast frames it appears as soon as the conversion finishes. In slow 16-clock frames it appears after the sixteenth falling edge. If a slow frame's eleventh rising edge comes too late, a sticky flag is set and the port goes silent until chip select is toggled.

Top module: `adc_serial_port`

## Requirements
- R1: The channel number is taken from `addr_in` MSB first, on the first four rising `sclk` edges of a frame, and appears on `conv_chan` with the first bit in bit 3. `addr_in` has no effect at any later rising edge of the frame.
- R2: After a qualified falling edge of chip select, `sdo` carries bit 9 of the stored result. Each falling `sclk` edge advances `sdo` to the next lower bit, so bit 0 is on the line after the ninth falling edge.
- R3: From the tenth falling edge until the frame ends, `sdo` is 0, including for clocks 11 to 16.
- R4: `sample_win` is 1 from the fourth falling edge to the tenth falling edge. At the tenth falling edge `conv_start` pulses high for exactly one internal cycle.
- R5: `sdo_en` (1 = line driven) is 0 whenever the qualified chip select is high. After reset `sdo_en`, `sample_win`, `conv_start` and `lost_sync` are 0 and `eoc` is 1.
- R6: A chip-select level that holds for fewer than `CS_QUAL` internal cycles is ignored.
- R7: `eoc` goes to 0 when a conversion starts. It returns to 1 on the cycle after `conv_done` is accepted, and the accepted `conv_result` becomes the stored result.
- R8: With chip select held low, if the conversion finishes after exactly 10 falling edges or after 16 falling edges, a new frame begins at once and `sdo` shows bit 9 of the new result.
- R9: With chip select held low, if the conversion finishes after 11 to 15 falling edges, `sdo` stays 0 until the sixteenth falling edge. At that edge a new frame begins and `sdo` shows bit 9 of the new result.
- R10: A rising `sclk` edge arriving more than `SYNC_LIMIT` internal cycles after the tenth falling edge, with no edge in between, sets `lost_sync`. While `lost_sync` is 1, `sdo` is 0 and `sclk` is ignored. Only a qualified falling edge of chip select clears it.
- R11: A qualified falling edge of chip select while a conversion is in flight cancels it. `eoc` returns to 1, a later `conv_done` is ignored, and the stored result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from host, active low, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| addr_in | input | 1 | Serial channel number from host |
| sdo | output | 1 | Serial result data |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means the line is released |
| sample_win | output | 1 | High while the selected input is being sampled |
| conv_start | output | 1 | One-cycle request to the conversion engine |
| conv_chan | output | ADDR_W | Channel number for the engine |
| conv_done | input | 1 | One-cycle completion pulse from the engine |
| conv_result | input | RES_W | Result word from the engine, valid with `conv_done` |
| eoc | output | 1 | End of conversion; 0 while a conversion is in flight |
| lost_sync | output | 1 | Sticky flag for a late eleventh clock |

## Verification
The assertions assume a few things about the inputs. Each `sclk` phase lasts long enough for the synchronizer and edge detector to see it, which takes three internal cycles. Chip select holds each level well beyond `CS_QUAL` cycles. `conv_done` is a single-cycle pulse that never lands on the same cycle as a detected `sclk` edge or a qualified chip-select edge. The stimulus keeps every `sclk` phase at six internal cycles, waits twenty cycles after each chip-select change, and places done pulses only in gaps between serial edges. The one deliberate break of the timing rules is the late eleventh clock that exercises the lost-sync path.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  localparam int RES_BITS     = 10;
  localparam int ADDR_BITS    = 4;
  localparam int FRAME_FALLS  = 16;
  localparam int OPEN_FALL    = 4;
  localparam int CONVERT_FALL = 10;
endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
  parameter int           N   = 1,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST[i];
        stab_q <= RST[i];
      end else begin
        meta_q <= din[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/adcsp_cs_qual.sv
module adcsp_cs_qual #(
  parameter int QUAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_lvl,
  output logic cs_q,
  output logic cs_fall_q
);
  localparam int          QW     = (QUAL > 2) ? $clog2(QUAL) : 1;
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL - 1);

  logic [QW-1:0] cnt_q, cnt_n;
  logic          lvl_q, lvl_n, fall_n;

  always_comb begin
    cnt_n  = '0;
    lvl_n  = lvl_q;
    fall_n = 1'b0;
    if (cs_lvl != lvl_q) begin
      if (cnt_q == Q_LAST) begin
        lvl_n  = cs_lvl;
        fall_n = ~cs_lvl;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lvl_q     <= 1'b1;
      cs_fall_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      lvl_q     <= lvl_n;
      cs_fall_q <= fall_n;
    end
  end

  assign cs_q = lvl_q;

  a_r6_fall_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> !$past(cs_lvl));
  a_r6_rise_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(cs_lvl));
endmodule

// File: rtl/adcsp_xfer.sv
module adcsp_xfer import adcsp_pkg::*; #(
  parameter int RES_W      = RES_BITS,
  parameter int ADDR_W     = ADDR_BITS,
  parameter int MAX_FALLS  = FRAME_FALLS,
  parameter int OPEN_AT    = OPEN_FALL,
  parameter int CONV_AT    = CONVERT_FALL,
  parameter int SYNC_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_q,
  input  logic              cs_fall_q,
  input  logic              sclk_lvl,
  input  logic              addr_lvl,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              sdo,
  output logic              sample_win,
  output logic              conv_start,
  output logic [ADDR_W-1:0] conv_chan,
  output logic              eoc,
  output logic              lost_sync
);
  localparam int CNT_W = $clog2(MAX_FALLS + 1);
  localparam int WIN_W = $clog2(SYNC_LIMIT + 1);
  localparam logic [CNT_W-1:0] C_ADDR     = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_OPEN_PRE = CNT_W'(OPEN_AT - 1);
  localparam logic [CNT_W-1:0] C_CONV_PRE = CNT_W'(CONV_AT - 1);
  localparam logic [CNT_W-1:0] C_CONV     = CNT_W'(CONV_AT);
  localparam logic [CNT_W-1:0] C_MAX      = CNT_W'(MAX_FALLS);
  localparam logic [CNT_W-1:0] C_MAX_PRE  = CNT_W'(MAX_FALLS - 1);
  localparam logic [WIN_W-1:0] W_LIM      = WIN_W'(SYNC_LIMIT);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [RES_W-1:0]  sh_q, sh_n, res_q, res_n;
  logic [WIN_W-1:0]  win_q, win_n;
  logic busy_q, busy_n, samp_q, samp_n, lost_q, lost_n, start_q, start_n;
  logic sclk_d_q, rise, fall, active;

  assign rise   = sclk_lvl & ~sclk_d_q;
  assign fall   = ~sclk_lvl & sclk_d_q;
  assign active = ~cs_q & ~lost_q;

  always_comb begin
    cnt_n   = cnt_q;
    addr_n  = addr_q;
    sh_n    = sh_q;
    res_n   = res_q;
    busy_n  = busy_q;
    samp_n  = samp_q;
    lost_n  = lost_q;
    start_n = 1'b0;
    if (cs_fall_q) begin
      cnt_n  = '0;
      sh_n   = res_q;
      lost_n = 1'b0;
      samp_n = 1'b0;
      busy_n = 1'b0;
    end else if (cs_q) begin
      samp_n = 1'b0;
    end else if (!lost_q) begin
      if (rise) begin
        if (cnt_q < C_ADDR) begin
          addr_n = {addr_q[ADDR_W-2:0], addr_lvl};
        end else if (cnt_q == C_CONV && win_q == W_LIM) begin
          lost_n = 1'b1;
        end
      end
      if (fall && cnt_q != C_MAX) begin
        cnt_n = cnt_q + 1'b1;
        sh_n  = {sh_q[RES_W-2:0], 1'b0};
        if (cnt_q == C_OPEN_PRE) samp_n = 1'b1;
        if (cnt_q == C_CONV_PRE) begin
          samp_n  = 1'b0;
          start_n = 1'b1;
          busy_n  = 1'b1;
        end
        if (cnt_q == C_MAX_PRE && !busy_q) begin
          cnt_n = '0;
          sh_n  = res_q;
        end
      end
    end
    if (conv_done && busy_q && !cs_fall_q) begin
      res_n  = conv_result;
      busy_n = 1'b0;
      if (active && (cnt_n == C_CONV || cnt_n == C_MAX)) begin
        cnt_n = '0;
        sh_n  = conv_result;
      end
    end
  end

  always_comb begin
    win_n = win_q;
    if (!active || cnt_q != C_CONV) win_n = '0;
    else if (win_q != W_LIM)        win_n = win_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      addr_q   <= '0;
      sh_q     <= '0;
      res_q    <= '0;
      win_q    <= '0;
      busy_q   <= 1'b0;
      samp_q   <= 1'b0;
      lost_q   <= 1'b0;
      start_q  <= 1'b0;
      sclk_d_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      addr_q   <= addr_n;
      sh_q     <= sh_n;
      res_q    <= res_n;
      win_q    <= win_n;
      busy_q   <= busy_n;
      samp_q   <= samp_n;
      lost_q   <= lost_n;
      start_q  <= start_n;
      sclk_d_q <= sclk_lvl;
    end
  end

  assign sdo        = sh_q[RES_W-1] & ~lost_q;
  assign sample_win = samp_q;
  assign conv_start = start_q;
  assign conv_chan  = addr_q;
  assign eoc        = ~busy_q;
  assign lost_sync  = lost_q;

  a_r1_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= C_ADDR) |=> $stable(addr_q));
  a_r3_low_after_tenth: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= C_CONV) |-> !sdo);
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  a_r7_done_raises_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy_q && !cs_fall_q) |=> eoc);
  a_r10_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !cs_fall_q) |=> lost_q);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port import adcsp_pkg::*; #(
  parameter int RES_W      = RES_BITS,
  parameter int ADDR_W     = ADDR_BITS,
  parameter int MAX_FALLS  = FRAME_FALLS,
  parameter int OPEN_AT    = OPEN_FALL,
  parameter int CONV_AT    = CONVERT_FALL,
  parameter int CS_QUAL    = 4,
  parameter int SYNC_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              addr_in,
  output logic              sdo,
  output logic              sdo_en,
  output logic              sample_win,
  output logic              conv_start,
  output logic [ADDR_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              eoc,
  output logic              lost_sync
);
  logic [1:0] rst_pipe_q;
  logic       rst_i;
  logic [2:0] lvl;
  logic       cs_q, cs_fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  adcsp_sync #(.N(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i), .din({cs_n, sclk, addr_in}), .q(lvl)
  );

  adcsp_cs_qual #(.QUAL(CS_QUAL)) u_csq (
    .clk(clk), .rst_n(rst_i), .cs_lvl(lvl[2]), .cs_q(cs_q), .cs_fall_q(cs_fall_q)
  );

  adcsp_xfer #(
    .RES_W(RES_W), .ADDR_W(ADDR_W), .MAX_FALLS(MAX_FALLS),
    .OPEN_AT(OPEN_AT), .CONV_AT(CONV_AT), .SYNC_LIMIT(SYNC_LIMIT)
  ) u_xfer (
    .clk(clk), .rst_n(rst_i), .cs_q(cs_q), .cs_fall_q(cs_fall_q),
    .sclk_lvl(lvl[1]), .addr_lvl(lvl[0]), .conv_done(conv_done),
    .conv_result(conv_result), .sdo(sdo), .sample_win(sample_win),
    .conv_start(conv_start), .conv_chan(conv_chan), .eoc(eoc),
    .lost_sync(lost_sync)
  );

  assign sdo_en = ~cs_q;

  a_r5_drive_needs_low_cs: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(sdo_en) |-> !$past(lvl[2]));
endmodule

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int SETTLE     = 20;
  localparam int LIMIT      = 200;
  localparam logic [13:0] VEC [8] = '{
    {4'h2, 10'h2A5}, {4'hB, 10'h3FF}, {4'h0, 10'h000}, {4'hD, 10'h155},
    {4'h5, 10'h200}, {4'hA, 10'h001}, {4'h7, 10'h2AA}, {4'hC, 10'h0F0}
  };

  logic clk, rst_n, cs_n, sclk, addr_in, conv_done;
  logic [9:0] conv_result;
  logic sdo, sdo_en, sample_win, conv_start, eoc, lost_sync;
  logic [3:0] conv_chan;

  adc_serial_port u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .addr_in(addr_in),
    .sdo(sdo), .sdo_en(sdo_en), .sample_win(sample_win), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
    .eoc(eoc), .lost_sync(lost_sync)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int starts   = 0;
  logic [3:0]  chan_seen = '0;
  logic [15:0] got, win;
  logic [9:0]  prev;

  always @(negedge clk) if (conv_start) begin
    starts    = starts + 1;
    chan_seen = conv_chan;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_set(input logic v);
    cs_n = v;
    idle(SETTLE);
  endtask

  task automatic clocks(input int first, input int last, input logic [3:0] a);
    for (int k = first; k <= last; k++) begin
      addr_in  = (k <= 4) ? a[4-k] : 1'b1;
      got[k-1] = sdo;
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
      idle(HALF);
      win[k-1] = sample_win;
    end
  endtask

  task automatic done_pulse(input logic [9:0] r);
    conv_result = r;
    conv_done   = 1'b1;
    idle(1);
    conv_done   = 1'b0;
    idle(4);
  endtask

  function automatic logic [9:0] word10(input logic [15:0] g);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[9-i] = g[i];
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    cs_n = 1'b1; sclk = 1'b0; addr_in = 1'b0; conv_done = 1'b0;
    conv_result = '0; rst_n = 1'b0; got = '0; win = '0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    // R5 reset state
    chk("R5 reset sdo_en", sdo_en, 0);
    chk("R5 reset eoc", eoc, 1);
    chk("R5 reset lost_sync", lost_sync, 0);
    chk("R5 reset sample_win", sample_win, 0);
    chk("R5 reset conv_start", conv_start, 0);
    prev = '0;

    for (int v = 0; v < 8; v++) begin
      logic [3:0] a;
      logic [9:0] r;
      int s0;
      a = VEC[v][13:10];
      r = VEC[v][9:0];
      s0 = starts;
      cs_set(1'b0);
      chk("R5 driven while selected", sdo_en, 1);
      clocks(1, 10, a);
      chk("R2 previous result", word10(got), prev);
      chk("R3 low after tenth", sdo, 0);
      chk("R4 one start", starts, s0 + 1);
      chk("R1 channel", chan_seen, a);
      chk("R7 eoc low", eoc, 0);
      done_pulse(r);
      chk("R7 eoc high", eoc, 1);
      cs_set(1'b1);
      chk("R5 released", sdo_en, 0);
      prev = r;
    end

    // R6 short glitch on chip select
    cs_n = 1'b0; idle(2); cs_n = 1'b1; idle(SETTLE);
    chk("R6 glitch ignored", sdo_en, 0);

    // 16-clock frame: zeros, sample window, address ignore
    cs_set(1'b0);
    clocks(1, 16, 4'h3);
    chk("R2 sixteen-clock frame", word10(got), prev);
    chk("R3 zeros on clocks 11-16", got[15:10], 0);
    chk("R4 closed after 3rd", win[2], 0);
    chk("R4 open after 4th", win[3], 1);
    chk("R4 open after 9th", win[8], 1);
    chk("R4 closed after 10th", win[9], 0);
    chk("R1 later address ignored", chan_seen, 4'h3);
    done_pulse(10'h1C3);
    cs_set(1'b1);

    // R8 continuous low, 10-clock frames
    cs_set(1'b0);
    clocks(1, 10, 4'h6);
    chk("R2 frame", word10(got), 10'h1C3);
    done_pulse(10'h2F0);
    chk("R8 new MSB at done", sdo, 1);
    clocks(1, 10, 4'h9);
    chk("R8 next frame result", word10(got), 10'h2F0);
    chk("R1 channel continuous", chan_seen, 4'h9);
    done_pulse(10'h00F);
    // R8 continuous low, fast 16-clock frame
    clocks(1, 16, 4'h1);
    chk("R8 16-clock frame result", word10(got), 10'h00F);
    chk("R3 zeros fast 16", got[15:10], 0);
    done_pulse(10'h3C0);
    chk("R8 new MSB after 16", sdo, 1);

    // R9 slow 16-clock frame
    clocks(1, 12, 4'h4);
    chk("R2 slow frame", word10(got), 10'h3C0);
    done_pulse(10'h255);
    chk("R9 held low before 16th", sdo, 0);
    clocks(13, 16, 4'h4);
    chk("R9 MSB after 16th", sdo, 1);
    clocks(1, 10, 4'h8);
    chk("R9 slow next result", word10(got), 10'h255);
    done_pulse(10'h0AA);
    cs_set(1'b1);

    // R10 lost synchronization
    cs_set(1'b0);
    clocks(1, 10, 4'h2);
    chk("R2 before lost", word10(got), 10'h0AA);
    idle(LIMIT + 20);
    clocks(11, 11, 4'h0);
    chk("R10 flag set", lost_sync, 1);
    done_pulse(10'h3FF);
    clocks(12, 16, 4'h0);
    chk("R10 no re-present", sdo, 0);
    chk("R10 sticky", lost_sync, 1);
    cs_set(1'b1);
    cs_set(1'b0);
    chk("R10 cleared by select", lost_sync, 0);
    chk("R10 result after recovery", sdo, 1);
    clocks(1, 10, 4'h0);
    chk("R10 full word after recovery", word10(got), 10'h3FF);
    done_pulse(10'h111);
    cs_set(1'b1);

    // R11 abort
    cs_set(1'b0);
    clocks(1, 10, 4'h5);
    chk("R7 busy before abort", eoc, 0);
    cs_set(1'b1);
    cs_set(1'b0);
    chk("R11 eoc after abort", eoc, 1);
    done_pulse(10'h2DD);
    chk("R11 late done no eoc change", eoc, 1);
    cs_set(1'b1);
    cs_set(1'b0);
    clocks(1, 10, 4'h0);
    chk("R11 result kept", word10(got), 10'h111);
    done_pulse(10'h123);
    cs_set(1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule